// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word-Addressed Registers

This block collects up to 32 interrupt request lines, latches them into a status word and combines them with a per-source enable mask to drive one interrupt line toward a processor. Software sees eight 32-bit registers on a small word-addressed bus. It reads raw and masked request state. It changes single enable bits through write-only set and clear aliases, so no read-modify-write is needed. It retires requests through a write-one-to-clear acknowledge register. It asks a vector register which source to service next: the lowest-numbered masked request wins.

Each line is fixed at build time as edge or level sensitive through a parameter mask. An edge line holds its request until software acknowledges it. A level line follows its input. A two-bit global gate must have both bits set before the processor line can assert. Register reads are combinational from the address. Writes take effect at the clock edge that samples them.

Top module: `irq_ctrl`

## Requirements
- R1: The register at word offset 0 is status, 1 is pending, 2 is enable, 3 is acknowledge, 4 is set-enable, 5 is clear-enable, 6 is vector and 7 is the global gate. Source n always uses bit n, and `rdata` shows the register selected by `addr` in the same cycle.
- R2: After reset, status, pending, enable and the gate read 0, `irq_o` is low, and the vector reads 0xFFFFFFFF.
- R3: A source whose `EDGE_MASK` bit is 1 is edge sensitive (default 0x0000FFFF: sources 0 to 15). Its status bit sets on a rising input and stays set after the input falls, until it is acknowledged.
- R4: A source whose `EDGE_MASK` bit is 0 is level sensitive. Its status bit loads the input value each clock. An acknowledge covering it loads 0 for that one clock, so if the input is still high the bit is 1 again one clock later.
- R5: Writing the acknowledge register clears each edge status bit whose written bit is 1 and leaves the others alone. A rising edge in the same cycle as the acknowledge wins, and the bit stays set. Writing all ones clears every latched edge request.
- R6: Writing the enable register replaces the whole mask. Writing 0 disables every source at once.
- R7: Writing set-enable sets each enable bit written as 1 and leaves the rest unchanged.
- R8: Writing clear-enable clears each enable bit written as 1 and leaves the rest unchanged.
- R9: Pending reads as status AND enable.
- R10: The vector reads the index of the lowest-numbered pending source, or 0xFFFFFFFF when no source is pending.
- R11: The gate register keeps written bits 1:0 and reads them back with zeros above. `irq_o` is high exactly when both gate bits are 1 and at least one source is pending.
- R12: Acknowledge, set-enable and clear-enable read as zero.
- R13: A register write becomes visible only after the clock edge that samples it. During the write cycle, a read still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is a rising edge that lands in the same clock as an acknowledge for the same source. To reach it, the bench drives the input high and places the acknowledge write on the same falling edge, so one rising clock edge samples both. The second hard case is acknowledging a level source whose input is still high. The bench reads status in the clock right after the acknowledge, and again one clock later, to see the short drop and the re-latch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 32;
    localparam int OFS_W  = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_RAW   = 3'd0,
        OFS_ACT   = 3'd1,
        OFS_MASK  = 3'd2,
        OFS_RETIRE= 3'd3,
        OFS_MSET  = 3'd4,
        OFS_MCLR  = 3'd5,
        OFS_VEC   = 3'd6,
        OFS_GATE  = 3'd7
    } ofs_e;

    typedef enum logic [1:0] {
        MASK_HOLD,
        MASK_LOAD,
        MASK_OR,
        MASK_ANDN
    } mask_op_e;

    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } winner_t;

    localparam logic [DATA_W-1:0] NO_VECTOR = '1;

    function automatic logic [DATA_W-1:0] vec_word(winner_t w);
        return w.hit ? {{(DATA_W-5){1'b0}}, w.idx} : NO_VECTOR;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] retire_i,
    output logic [NUM_SRC-1:0] status_o
);

    logic [NUM_SRC-1:0] src_q;

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_i;
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_line
        if (EDGE_MASK[n]) begin : g_edge
            logic rise;
            assign rise = src_i[n] & ~src_q[n];
            always_ff @(posedge clk) begin
                if (rst)       status_o[n] <= 1'b0;
                else if (rise) status_o[n] <= 1'b1;
                else if (retire_i[n]) status_o[n] <= 1'b0;
            end
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (rst) status_o[n] <= 1'b0;
                else     status_o[n] <= src_i[n] & ~retire_i[n];
            end
        end
    end

endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  mask_op_e           op_i,
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [NUM_SRC-1:0] enable_o
);

    logic [NUM_SRC-1:0] nxt;

    always_comb begin
        unique case (op_i)
            MASK_LOAD: nxt = bits_i;
            MASK_OR:   nxt = enable_o | bits_i;
            MASK_ANDN: nxt = enable_o & ~bits_i;
            default:   nxt = enable_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) enable_o <= '0;
        else     enable_o <= nxt;
    end

endmodule

// File: rtl/irqc_vector.sv
module irqc_vector
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] pending_i,
    output winner_t            win_o
);

    always_comb begin
        win_o = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (pending_i[n]) begin
                win_o.hit = 1'b1;
                win_o.idx = 5'(n);
            end
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 irq_o
);

    ofs_e               sel;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] retire;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pending;
    logic [1:0]         gate_q;
    mask_op_e           mop;
    winner_t            win;

    assign sel    = ofs_e'(addr);
    assign wbits  = wdata[NUM_SRC-1:0];
    assign retire = (wr_en && sel == OFS_RETIRE) ? wbits : '0;

    always_comb begin
        mop = MASK_HOLD;
        if (wr_en) begin
            unique case (sel)
                OFS_MASK: mop = MASK_LOAD;
                OFS_MSET: mop = MASK_OR;
                OFS_MCLR: mop = MASK_ANDN;
                default:  mop = MASK_HOLD;
            endcase
        end
    end

    irqc_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk(clk), .rst(rst), .src_i(src_i), .retire_i(retire), .status_o(status_q)
    );

    irqc_enable #(.NUM_SRC(NUM_SRC)) u_en (
        .clk(clk), .rst(rst), .op_i(mop), .bits_i(wbits), .enable_o(enable_q)
    );

    assign pending = status_q & enable_q;

    irqc_vector #(.NUM_SRC(NUM_SRC)) u_vec (
        .pending_i(pending), .win_o(win)
    );

    always_ff @(posedge clk) begin
        if (rst)                             gate_q <= 2'b00;
        else if (wr_en && sel == OFS_GATE)   gate_q <= wdata[1:0];
    end

    assign irq_o = (&gate_q) & (|pending);

    always_comb begin
        unique case (sel)
            OFS_RAW:  rdata = DATA_W'(status_q);
            OFS_ACT:  rdata = DATA_W'(pending);
            OFS_MASK: rdata = DATA_W'(enable_q);
            OFS_VEC:  rdata = vec_word(win);
            OFS_GATE: rdata = {{(DATA_W-2){1'b0}}, gate_q};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_i,
    input logic               wr_en,
    input logic [2:0]         addr,
    input logic [31:0]        wdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] enable,
    input logic [1:0]         gate
);

    localparam logic [NUM_SRC-1:0] EDGES = EDGE_MASK[NUM_SRC-1:0];

    logic [NUM_SRC-1:0] prev_src;
    logic [NUM_SRC-1:0] ackw;
    logic [NUM_SRC-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) prev_src <= '0;
        else     prev_src <= src_i;
    end

    assign ackw = (wr_en && addr == 3'd3) ? wdata[NUM_SRC-1:0] : '0;
    assign rise = src_i & ~prev_src;

    // R7
    p_set_enable_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd4) |=> (enable == ($past(enable) | $past(wdata[NUM_SRC-1:0]))));

    // R8
    p_clr_enable_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd5) |=> (enable == ($past(enable) & ~$past(wdata[NUM_SRC-1:0]))));

    // R5
    p_ack_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (|ackw) |=> ((status & EDGES & $past(ackw) & ~$past(rise)) == '0));

    // R3
    p_edge_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (|(rise & EDGES)) |=> ((status & $past(rise) & EDGES) == ($past(rise) & EDGES)));

    // R4
    p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~EDGES) == ($past(src_i) & ~$past(ackw) & ~EDGES)));

    // R11
    p_gate_r11: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (gate == 2'b11 && (|(status & enable))));

endmodule

bind irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_chk (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .irq_o(irq_o), .status(status_q), .enable(enable_q), .gate(gate_q)
);

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_i = '0;
    logic            wr_en = 1'b0;
    logic [2:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq_o;

    int compared = 0;
    int mismatched = 0;

    irq_ctrl #(.NUM_SRC(NSRC), .EDGE_MASK(32'h0000_FFFF)) uut (
        .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd(3'd0, 32'h0, "R2 status");
        rd(3'd1, 32'h0, "R2 pending");
        rd(3'd2, 32'h0, "R2 enable");
        rd(3'd6, 32'hFFFF_FFFF, "R2 vector");
        rd(3'd7, 32'h0, "R2 gate");
        check("R2 irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_enable();
        wr(3'd2, 32'h0000_00F0);
        rd(3'd2, 32'h0000_00F0, "R6 load");
        wr(3'd4, 32'h0F00_0001);
        rd(3'd2, 32'h0F00_00F1, "R7 set");
        wr(3'd5, 32'h0000_0030);
        rd(3'd2, 32'h0F00_00C1, "R8 clear");
        rd(3'd3, 32'h0, "R12 ack reads 0");
        rd(3'd4, 32'h0, "R12 set reads 0");
        rd(3'd5, 32'h0, "R12 clr reads 0");
        // R13: write in flight, old value still visible
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd2; wdata = 32'h0;
        #1;
        check("R13 before edge", rdata, 32'h0F00_00C1);
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd2, 32'h0, "R6 write zero disables all");
    endtask

    task automatic t_edge();
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd7, 32'h3);
        @(negedge clk); src_i[5] = 1'b1;
        @(negedge clk); src_i[5] = 1'b0;
        tick();
        rd(3'd0, 32'h0000_0020, "R3 edge held after fall");
        rd(3'd1, 32'h0000_0020, "R9 pending");
        rd(3'd6, 32'd5, "R10 vector 5");
        check("R11 irq high", 32'(irq_o), 32'h1);
        @(negedge clk); src_i[3] = 1'b1;
        @(negedge clk); src_i[3] = 1'b0;
        rd(3'd6, 32'd3, "R10 lowest wins");
        wr(3'd3, 32'h0000_0008);
        rd(3'd0, 32'h0000_0020, "R5 ack one bit");
        rd(3'd6, 32'd5, "R10 after ack");
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd0, 32'h0, "R5 ack all");
        rd(3'd6, 32'hFFFF_FFFF, "R10 none pending");
        check("R11 irq low", 32'(irq_o), 32'h0);
    endtask

    task automatic t_race();
        @(negedge clk);
        src_i[2] = 1'b1;
        wr_en = 1'b1; addr = 3'd3; wdata = 32'h4;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd0, 32'h0000_0004, "R5 rise beats ack");
        wr(3'd3, 32'h4);
        rd(3'd0, 32'h0, "R3 ack with input high clears edge");
        src_i[2] = 1'b0;
        tick();
    endtask

    task automatic t_level();
        @(negedge clk); src_i[20] = 1'b1;
        tick();
        rd(3'd0, 32'h0010_0000, "R4 level follows");
        rd(3'd6, 32'd20, "R10 vector 20");
        wr(3'd3, 32'h0010_0000);
        rd(3'd0, 32'h0, "R4 ack cycle drop");
        tick();
        rd(3'd0, 32'h0010_0000, "R4 relatched");
    endtask

    task automatic t_gate();
        wr(3'd7, 32'h1);
        check("R11 gate 01", 32'(irq_o), 32'h0);
        wr(3'd7, 32'h2);
        check("R11 gate 10", 32'(irq_o), 32'h0);
        wr(3'd7, 32'hFFFF_FFFF);
        check("R11 gate 11", 32'(irq_o), 32'h1);
        rd(3'd7, 32'h3, "R11 gate readback");
        @(negedge clk); src_i[5] = 1'b1;
        @(negedge clk); src_i[5] = 1'b0;
        rd(3'd0, 32'h0010_0020, "R1 status bit map");
        wr(3'd2, 32'h0010_0000);
        rd(3'd1, 32'h0010_0000, "R9 masked pending");
        rd(3'd6, 32'd20, "R10 masked lower source");
        wr(3'd2, 32'h0000_0020);
        rd(3'd6, 32'd5, "R10 vector 5 again");
        wr(3'd2, 32'h0);
        rd(3'd1, 32'h0, "R6 all disabled");
        check("R6 irq low", 32'(irq_o), 32'h0);
        src_i[20] = 1'b0;
        tick();
        rd(3'd0, 32'h0000_0020, "R4 level falls");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_enable();
        t_edge();
        t_race();
        t_level();
        t_gate();
        tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule